// File: doc/BRIEF.md
# Banked Display Aperture Translator

This block sits between the CPU bus and video memory. It takes byte accesses that fall in the legacy display aperture (0xA0000 to 0xBFFFF) and turns them into video memory addresses. A 2-bit memory-map selector picks one of four aperture layouts. One layout is a 64 KiB window whose base in video memory is set by a bank number.

The bank number and an extended-mode enable come from the mode register file. When the extended mode is on, the block always uses the banked 64 KiB window, whatever the selector says. When the extended mode is off, the bank base falls back to zero. In that case the window maps onto the first 64 KiB of video memory.

For each access the block reports whether it hit the current region. On a hit it gives the translated address and passes the read and write strobes through. On a miss it suppresses both strobes, and a read miss gets the fill byte 0xFF.

Top module: `win_xlate`

## Requirements
- R1: While `ext_en` is 1 the block decodes every access as the banked window (selector value 1), ignoring `map_mode`.
- R2: In window mode, only bus addresses 0xA0000 to 0xAFFFF hit; any address at or above 0xB0000 misses.
- R3: In window mode a hit yields `vmem_addr = (bus_addr - 0xA0000 + bank*0x10000) mod 2^VMEM_AW`, where bank is the stored bank number.
- R4: A bank write (`bank_we`=1 with `ext_en`=1) stores the low VMEM_AW-16 bits of `bank_in`; higher bits are ignored. The new bank takes effect from the cycle after the write edge; the access in the write cycle itself still uses the old bank.
- R5: After reset, and at any time `ext_en` is 0, the effective bank is 0, so window address 0xA0000 maps to 0. A bank write while `ext_en` is 0 is discarded, and the bank reads as 0 after re-enabling.
- R6: With selector value 0, addresses 0xA0000 to 0xBFFFF hit and map to `bus_addr - 0xA0000`.
- R7: With selector value 2, addresses 0xB0000 to 0xB7FFF hit and map to `bus_addr - 0xB0000`. With selector value 3, addresses 0xB8000 to 0xBFFFF hit and map to `bus_addr - 0xB8000`.
- R8: No bus address below 0xA0000 hits in any mode.
- R9: On a miss, `vmem_rd` and `vmem_wr` are 0 and `vmem_addr` is 0. If `rd` is 1, `fill_data` is 0xFF.
- R10: On a hit, `vmem_rd` equals `rd`, `vmem_wr` equals `wr`, and `fill_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | CPU byte address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| map_mode | input | 2 | Memory-map selector (0: 128 KiB, 1: banked window, 2: low 32 KiB at 0xB0000, 3: high 32 KiB at 0xB8000) |
| ext_en | input | 1 | Extended mode enable from the mode register file |
| bank_we | input | 1 | Bank register write strobe |
| bank_in | input | 16 | Bank number write data |
| hit | output | 1 | Access falls inside the active region |
| vmem_addr | output | VMEM_AW | Translated video memory address (0 on miss) |
| vmem_rd | output | 1 | Read forwarded to video memory |
| vmem_wr | output | 1 | Write forwarded to video memory |
| fill_data | output | 8 | Read data to return on a read miss |

## Verification
The bench goes after the region edges: 0x9FFFF, 0xA0000, 0xAFFFF, 0xB0000, 0xB7FFF, 0xB8000, 0xBFFFF and 0xC0000. These are checked in every selector and enable combination. A decoder with an off-by-one ceiling would let a window access at 0xB0000 through, or would drop the top byte of a region. Bank handling is checked with writes that carry junk in the high bits, and the bank is sampled on both sides of the write edge. A design that registered the bank one cycle late, or skipped the mask, would land accesses in the wrong 64 KiB page. Disabling the extended mode with a nonzero bank stored, and writing a bank while disabled, exposes a design that keeps a stale offset. Such a design maps the window away from address 0.

// File: rtl/win_pkg.sv
package win_pkg;

    typedef enum logic [1:0] {
        MAP_128K  = 2'd0,
        MAP_WIN64 = 2'd1,
        MAP_LO32  = 2'd2,
        MAP_HI32  = 2'd3
    } map_e;

    localparam int unsigned WIN_SHIFT = 16;
    localparam int unsigned OFFS_W    = 17;
    localparam logic [7:0]  FILL_BYTE = 8'hFF;

    typedef struct packed {
        logic              hit;
        logic [OFFS_W-1:0] offs;
    } region_t;

    // Region check and offset inside the region for one map layout
    function automatic region_t region_of(map_e m, logic [19:0] a);
        region_t r;
        r.hit  = 1'b0;
        r.offs = '0;
        unique case (m)
            MAP_128K: begin
                r.hit  = (a[19:17] == 3'b101);
                r.offs = a[16:0];
            end
            MAP_WIN64: begin
                r.hit  = (a[19:16] == 4'hA);
                r.offs = {1'b0, a[15:0]};
            end
            MAP_LO32: begin
                r.hit  = (a[19:15] == 5'b10110);
                r.offs = {2'b00, a[14:0]};
            end
            MAP_HI32: begin
                r.hit  = (a[19:15] == 5'b10111);
                r.offs = {2'b00, a[14:0]};
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/win_bank_reg.sv
module win_bank_reg #(
    parameter int unsigned BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_en,
    input  logic              bank_we,
    input  logic [15:0]       bank_in,
    output logic [BANK_W-1:0] bank_eff
);
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst || !ext_en) begin
            bank_q <= '0;
        end else if (bank_we) begin
            bank_q <= bank_in[BANK_W-1:0];
        end
    end

    // Disabled extended mode forces the base back to zero at once
    assign bank_eff = ext_en ? bank_q : '0;
endmodule

// File: rtl/win_region_dec.sv
module win_region_dec
    import win_pkg::*;
(
    input  logic [19:0] bus_addr,
    input  logic [1:0]  map_mode,
    input  logic        ext_en,
    output map_e        mode_eff,
    output region_t     region
);
    always_comb begin
        mode_eff = ext_en ? MAP_WIN64 : map_e'(map_mode);
        region   = region_of(mode_eff, bus_addr);
    end
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
    import win_pkg::*;
#(
    parameter int unsigned VMEM_AW = 22
) (
    input  region_t                   region,
    input  map_e                      mode_eff,
    input  logic [VMEM_AW-WIN_SHIFT-1:0] bank,
    output logic [VMEM_AW-1:0]        vmem_addr
);
    localparam int unsigned SUM_W = ((VMEM_AW > OFFS_W) ? VMEM_AW : OFFS_W) + 1;

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;

    always_comb begin
        base      = (mode_eff == MAP_WIN64) ? SUM_W'({bank, {WIN_SHIFT{1'b0}}}) : '0;
        sum       = base + SUM_W'(region.offs);
        vmem_addr = region.hit ? sum[VMEM_AW-1:0] : '0;
    end
endmodule

// File: rtl/win_xlate.sv
module win_xlate
    import win_pkg::*;
#(
    parameter int unsigned VMEM_AW = 22
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [19:0]        bus_addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [1:0]         map_mode,
    input  logic               ext_en,
    input  logic               bank_we,
    input  logic [15:0]        bank_in,
    output logic               hit,
    output logic [VMEM_AW-1:0] vmem_addr,
    output logic               vmem_rd,
    output logic               vmem_wr,
    output logic [7:0]         fill_data
);
    localparam int unsigned BANK_W = VMEM_AW - WIN_SHIFT;

    logic [BANK_W-1:0] bank_eff;
    map_e              mode_eff;
    region_t           region;

    win_bank_reg #(.BANK_W(BANK_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .ext_en   (ext_en),
        .bank_we  (bank_we),
        .bank_in  (bank_in),
        .bank_eff (bank_eff)
    );

    win_region_dec dec_i (
        .bus_addr (bus_addr),
        .map_mode (map_mode),
        .ext_en   (ext_en),
        .mode_eff (mode_eff),
        .region   (region)
    );

    win_addr_gen #(.VMEM_AW(VMEM_AW)) agen_i (
        .region    (region),
        .mode_eff  (mode_eff),
        .bank      (bank_eff),
        .vmem_addr (vmem_addr)
    );

    assign hit       = region.hit;
    assign vmem_rd   = rd & region.hit;
    assign vmem_wr   = wr & region.hit;
    assign fill_data = (rd && !region.hit) ? FILL_BYTE : 8'h00;
endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk #(
    parameter int unsigned VMEM_AW = 22
) (
    input logic               clk,
    input logic               rst,
    input logic [19:0]        bus_addr,
    input logic               rd,
    input logic               wr,
    input logic [1:0]         map_mode,
    input logic               ext_en,
    input logic               bank_we,
    input logic [15:0]        bank_in,
    input logic               hit,
    input logic [VMEM_AW-1:0] vmem_addr,
    input logic               vmem_rd,
    input logic               vmem_wr,
    input logic [7:0]         fill_data
);
    localparam int unsigned BW = VMEM_AW - 16;

    // R1
    ext_forces_window_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_en && bus_addr[19:16] == 4'hA && map_mode != 2'd1) |-> hit);

    // R2
    win_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_en && bus_addr >= 20'hB0000) |-> !hit);

    // R4
    bank_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(ext_en && bank_we) && ext_en && hit)
        |-> vmem_addr[VMEM_AW-1:16] == $past(bank_in[BW-1:0]));

    // R5
    disabled_base_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_en && map_mode == 2'd1 && hit) |-> vmem_addr == VMEM_AW'(bus_addr[15:0]));

    // R8
    below_aperture_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr < 20'hA0000) |-> !hit);

    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (!vmem_rd && !vmem_wr && vmem_addr == '0
                  && fill_data == (rd ? 8'hFF : 8'h00)));

    // R10
    hit_pass_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (vmem_rd == rd && vmem_wr == wr && fill_data == 8'h00));
endmodule

bind win_xlate win_xlate_chk #(.VMEM_AW(VMEM_AW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .rd        (rd),
    .wr        (wr),
    .map_mode  (map_mode),
    .ext_en    (ext_en),
    .bank_we   (bank_we),
    .bank_in   (bank_in),
    .hit       (hit),
    .vmem_addr (vmem_addr),
    .vmem_rd   (vmem_rd),
    .vmem_wr   (vmem_wr),
    .fill_data (fill_data)
);

// File: tb/win_xlate_tb.sv
module win_xlate_tb_top;
    localparam int unsigned AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [19:0]   bus_addr = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    map_mode = '0;
    logic          ext_en = 1'b0;
    logic          bank_we = 1'b0;
    logic [15:0]   bank_in = '0;
    logic          hit;
    logic [AW-1:0] vmem_addr;
    logic          vmem_rd;
    logic          vmem_wr;
    logic [7:0]    fill_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int bank_model = 0;

    win_xlate #(.VMEM_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .rd(rd), .wr(wr),
        .map_mode(map_mode), .ext_en(ext_en), .bank_we(bank_we), .bank_in(bank_in),
        .hit(hit), .vmem_addr(vmem_addr), .vmem_rd(vmem_rd), .vmem_wr(vmem_wr),
        .fill_data(fill_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (got %0d cycles, expected < 190000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        checks = checks + 1;
        if (got != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s addr=%h mode=%0d ext=%0d: got %h expected %h",
                     tag, what, bus_addr, map_mode, ext_en, got, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic probe(input logic [19:0] a);
        int m, base, top, bnk;
        bit eh;
        longint ea;
        string tag;
        bus_addr = a;
        rd = a[0];
        wr = a[1];
        #1;
        m   = ext_en ? 1 : int'(map_mode);
        bnk = ext_en ? bank_model : 0;
        case (m)
            0: begin base = 'hA0000; top = 'hBFFFF; tag = "R6"; end
            1: begin base = 'hA0000; top = 'hAFFFF; tag = ext_en ? "R1" : "R5"; end
            2: begin base = 'hB0000; top = 'hB7FFF; tag = "R7"; end
            default: begin base = 'hB8000; top = 'hBFFFF; tag = "R7"; end
        endcase
        if (m == 1 && ext_en && a >= 20'hB0000) tag = "R2";
        if (a < 20'hA0000) tag = "R8";
        eh = (int'(a) >= base) && (int'(a) <= top);
        ea = eh ? ((longint'(a) - base + (m == 1 ? longint'(bnk) * 65536 : 0)) % (longint'(1) << AW)) : 0;
        chk(tag, "hit", hit, eh);
        chk(m == 1 ? "R3" : tag, "vmem_addr", vmem_addr, ea);
        if (eh) begin
            chk("R10", "vmem_rd", vmem_rd, rd);
            chk("R10", "vmem_wr", vmem_wr, wr);
            chk("R10", "fill", fill_data, 0);
        end else begin
            chk("R9", "vmem_rd", vmem_rd, 0);
            chk("R9", "vmem_wr", vmem_wr, 0);
            chk("R9", "fill", fill_data, rd ? 8'hFF : 8'h00);
        end
    endtask

    task automatic sweep();
        for (int a = 'h9F000; a < 'hC1000; a += 'h3B) probe(20'(a));
        probe(20'h9FFFF); probe(20'hA0000); probe(20'hAFFFF); probe(20'hB0000);
        probe(20'hB7FFF); probe(20'hB8000); probe(20'hBFFFF); probe(20'hC0000);
        probe(20'h00000); probe(20'hFFFFF);
    endtask

    task automatic write_bank(input logic [15:0] v);
        @(negedge clk);
        bank_in = v;
        bank_we = 1'b1;
        @(posedge clk);
        if (ext_en) bank_model = int'(v[AW-17:0]);
        else bank_model = 0;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    initial begin
        ext_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: reset state, window base is 0
        probe(20'hA0000);
        chk("R5", "reset vmem_addr", vmem_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        probe(20'hA1234);

        for (int b = 0; b < 4; b++) begin
            ext_en = 1'b1;
            // R4: high bits carry junk that must be masked off
            write_bank(16'(b + 4 * (b + 5)));
            for (int m = 0; m < 4; m++) begin
                map_mode = 2'(m);
                sweep();
            end
            ext_en = 1'b0;
            for (int m = 0; m < 4; m++) begin
                map_mode = 2'(m);
                sweep();
            end
            @(negedge clk);
        end

        // R4: bank timing around the write edge
        ext_en = 1'b1;
        map_mode = 2'd0;
        write_bank(16'h0001);
        @(negedge clk);
        bank_in = 16'hFF03;
        bank_we = 1'b1;
        probe(20'hA0010);
        chk("R4", "old bank before edge", vmem_addr, 18'h10010);
        @(posedge clk);
        bank_model = 3;
        @(negedge clk);
        bank_we = 1'b0;
        probe(20'hA0010);
        chk("R4", "new bank after edge", vmem_addr, 18'h30010);

        // R5: write while disabled is dropped; re-enable gives bank 0
        ext_en = 1'b0;
        write_bank(16'h0002);
        ext_en = 1'b1;
        @(negedge clk);
        probe(20'hA0020);
        chk("R5", "bank after re-enable", vmem_addr, 18'h00020);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule